// File: doc/BRIEF.md
# Destination Address Hash Filter

This block sits behind a receive MAC and decides whether an incoming Ethernet frame is kept, judging only by its 48-bit destination address. The six destination bytes arrive one per cycle on a byte stream whose first byte is flagged. While the bytes go by, the block folds each one into a CRC-32. One cycle after the sixth byte it gives a one-cycle verdict together with the 6-bit hash index it used.

Configuration comes in through a simple word-wide write port. The port loads a 64-bit multicast hash table held as two 32-bit words, a mode word and six station-address bytes. Unicast destinations are matched exactly against the station address, or all of them pass in promiscuous mode. The all-ones broadcast address has its own accept bit. Every other group address is looked up in the hash table. That lookup only applies when a multicast enable is active. The enable is derived from the table contents and from the all-multicast and promiscuous modes.

The control is a three-state machine. ST_IDLE waits for a flagged first byte (transition IDLE->GATHER). ST_GATHER collects bytes: a new first byte restarts it (GATHER->GATHER), and the sixth byte moves it on (GATHER->VERDICT). ST_VERDICT presents the result for one cycle, then returns to idle (VERDICT->IDLE), or goes back to gathering if a new first byte arrives in that cycle (VERDICT->GATHER).

Top module: `eth_mcast_filter`

## Requirements
- R1: After reset dec_valid and dec_accept are 0, and every configuration register (hash words, mode, station bytes) is 0.
- R2: dec_valid is 1 for exactly one cycle: the cycle after the clock edge that takes the sixth destination byte. A byte counts only when rx_valid is 1. A byte with rx_first set restarts collection as byte 0. Bytes with rx_valid set but no frame in progress are ignored.
- R3: dec_accept is 0 whenever dec_valid is 0.
- R4: dec_index equals bits 31:26 of the bitwise complement of a CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF. The CRC register shifts left, and each destination byte is fed least significant bit first, in arrival order.
- R5: Hash index i below 32 selects bit i of the word at config address 0. Index i of 32 or above selects bit i-32 of the word at config address 1.
- R6: A multicast destination is one whose first byte has bit 0 set and which is not all ones. It is accepted only when the multicast enable is active and the indexed table bit is 1. The enable is active when any table bit is 1, or when all-multicast or promiscuous mode is set; it is inactive otherwise.
- R7: With all-multicast (mode word at address 2, bit 2) or promiscuous mode set, the table is treated as all ones, so every multicast destination is accepted.
- R8: A unicast destination (first byte bit 0 clear) is accepted when it equals the station address, or when promiscuous mode (mode bit 0) is set. Station byte k lives at config address 3+k in wdata[7:0] and is compared with the k-th received byte.
- R9: The all-ones destination is accepted if and only if broadcast accept (mode bit 1) is set, whatever the other mode bits and the table hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| rx_valid | input | 1 | A destination byte is present |
| rx_first | input | 1 | The present byte is the first of a destination address |
| rx_byte | input | 8 | Destination byte |
| dec_valid | output | 1 | Verdict strobe |
| dec_accept | output | 1 | Frame accepted (qualified by dec_valid) |
| dec_index | output | 6 | Hash index computed for the address |

## Verification
The verdict is due in exactly one cycle. The bench drives bytes on the falling edge, so the sixth byte is registered at the following rising edge. It then samples dec_valid, dec_accept and dec_index at the next falling edge. It also checks the cycle after that, where dec_valid must have fallen. The bench inserts idle gaps between bytes and samples dec_valid during each gap, which shows that no verdict comes early. Configuration writes are done a full cycle before the first byte of the frame they are meant to affect.

// File: rtl/filt_pkg.sv
package filt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GATHER  = 2'd1,
        ST_VERDICT = 2'd2
    } filt_state_e;

    localparam int MODE_W        = 3;
    localparam int MODE_PROMISC  = 0;
    localparam int MODE_BCAST    = 1;
    localparam int MODE_ALLMC    = 2;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

endpackage

// File: rtl/filt_crc8.sv
module filt_crc8
    import filt_pkg::*;
(
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       din,
    output logic [CRC_W-1:0] crc_out
);

    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = crc_in;
        for (int b = 0; b < 8; b++) begin
            fb  = acc[CRC_W-1] ^ din[b];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ CRC_POLY;
            end
        end
        crc_out = acc;
    end

endmodule

// File: rtl/filt_cfg_regs.sv
module filt_cfg_regs
    import filt_pkg::*;
#(
    parameter int REG_W      = 32,
    parameter int HASH_BITS  = 6,
    parameter int ADDR_BYTES = 6,
    parameter int CFG_AW     = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [CFG_AW-1:0]         addr,
    input  logic [REG_W-1:0]          wdata,
    output logic [(1<<HASH_BITS)-1:0] hash_tbl,
    output logic [MODE_W-1:0]         mode,
    output logic [8*ADDR_BYTES-1:0]   station
);

    localparam int TBL_W      = 1 << HASH_BITS;
    localparam int HASH_WORDS = TBL_W / REG_W;
    localparam int MODE_ADDR  = HASH_WORDS;
    localparam int STA_BASE   = HASH_WORDS + 1;

    logic [REG_W-1:0]  hash_w [HASH_WORDS];
    logic [7:0]        sta_b  [ADDR_BYTES];
    logic [MODE_W-1:0] mode_q;

    for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hash_w[w] <= '0;
            end else if (we && addr == CFG_AW'(w)) begin
                hash_w[w] <= wdata;
            end
        end
        assign hash_tbl[w*REG_W +: REG_W] = hash_w[w];
    end

    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_sta
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sta_b[k] <= '0;
            end else if (we && addr == CFG_AW'(STA_BASE + k)) begin
                sta_b[k] <= wdata[7:0];
            end
        end
        assign station[8*k +: 8] = sta_b[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (we && addr == CFG_AW'(MODE_ADDR)) begin
            mode_q <= wdata[MODE_W-1:0];
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/filt_verdict.sv
module filt_verdict
    import filt_pkg::*;
#(
    parameter int HASH_BITS  = 6,
    parameter int ADDR_BYTES = 6
) (
    input  logic [8*ADDR_BYTES-1:0]   dst,
    input  logic [HASH_BITS-1:0]      crc_top,
    input  logic [(1<<HASH_BITS)-1:0] hash_tbl,
    input  logic [MODE_W-1:0]         mode,
    input  logic [8*ADDR_BYTES-1:0]   station,
    output logic                      accept_raw,
    output logic [HASH_BITS-1:0]      idx
);

    localparam int TBL_W = 1 << HASH_BITS;

    logic             is_bcast;
    logic             is_mc;
    logic             force_all;
    logic             mc_en;
    logic [TBL_W-1:0] tbl_eff;
    logic             hit;

    always_comb begin
        idx       = ~crc_top;
        is_bcast  = &dst;
        is_mc     = dst[0];
        force_all = mode[MODE_ALLMC] | mode[MODE_PROMISC];
        mc_en     = force_all | (|hash_tbl);
        tbl_eff   = force_all ? {TBL_W{1'b1}} : hash_tbl;
        hit       = tbl_eff[idx];
        if (is_bcast) begin
            accept_raw = mode[MODE_BCAST];
        end else if (is_mc) begin
            accept_raw = mc_en & hit;
        end else begin
            accept_raw = mode[MODE_PROMISC] | (dst == station);
        end
    end

endmodule

// File: rtl/eth_mcast_filter.sv
module eth_mcast_filter
    import filt_pkg::*;
#(
    parameter int REG_W      = 32,
    parameter int HASH_BITS  = 6,
    parameter int ADDR_BYTES = 6,
    parameter int CFG_AW     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [REG_W-1:0]     cfg_wdata,
    input  logic                 rx_valid,
    input  logic                 rx_first,
    input  logic [7:0]           rx_byte,
    output logic                 dec_valid,
    output logic                 dec_accept,
    output logic [HASH_BITS-1:0] dec_index
);

    localparam int TBL_W  = 1 << HASH_BITS;
    localparam int DST_W  = 8 * ADDR_BYTES;
    localparam int CNT_W  = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_HELD = CNT_W'(ADDR_BYTES - 1);

    filt_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DST_W-1:0]  dst_q;
    logic [CRC_W-1:0]  crc_q;
    logic [CRC_W-1:0]  crc_seed;
    logic [CRC_W-1:0]  crc_next;
    logic              take_first;
    logic              take_more;

    logic [TBL_W-1:0]  hash_tbl;
    logic [MODE_W-1:0] mode;
    logic [DST_W-1:0]  station;
    logic              accept_raw;
    logic [HASH_BITS-1:0] idx;

    filt_cfg_regs #(
        .REG_W(REG_W), .HASH_BITS(HASH_BITS),
        .ADDR_BYTES(ADDR_BYTES), .CFG_AW(CFG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .hash_tbl(hash_tbl), .mode(mode),
        .station(station)
    );

    assign take_first = rx_valid & rx_first;
    assign take_more  = rx_valid & ~rx_first & (state_q == ST_GATHER);
    assign crc_seed   = take_first ? CRC_INIT : crc_q;

    filt_crc8 u_crc (
        .crc_in(crc_seed), .din(rx_byte), .crc_out(crc_next)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_first) state_d = ST_GATHER;
            end
            ST_GATHER: begin
                if (take_first) begin
                    state_d = ST_GATHER;
                end else if (take_more && cnt_q == LAST_HELD) begin
                    state_d = ST_VERDICT;
                end
            end
            ST_VERDICT: begin
                state_d = take_first ? ST_GATHER : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // byte capture and CRC accumulation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dst_q <= '0;
            crc_q <= CRC_INIT;
        end else if (take_first) begin
            cnt_q      <= CNT_W'(1);
            dst_q      <= '0;
            dst_q[7:0] <= rx_byte;
            crc_q      <= crc_next;
        end else if (take_more) begin
            cnt_q                      <= cnt_q + CNT_W'(1);
            dst_q[8*int'(cnt_q) +: 8]  <= rx_byte;
            crc_q                      <= crc_next;
        end
    end

    filt_verdict #(
        .HASH_BITS(HASH_BITS), .ADDR_BYTES(ADDR_BYTES)
    ) u_verdict (
        .dst(dst_q), .crc_top(crc_q[CRC_W-1 -: HASH_BITS]),
        .hash_tbl(hash_tbl), .mode(mode), .station(station),
        .accept_raw(accept_raw), .idx(idx)
    );

    // outputs
    always_comb begin
        dec_valid  = (state_q == ST_VERDICT);
        dec_accept = dec_valid & accept_raw;
        dec_index  = idx;
    end

endmodule

// File: rtl/filt_hash_chk.sv
module filt_hash_chk
    import filt_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int TBL_W      = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rx_valid,
    input logic                    rx_first,
    input logic                    dec_valid,
    input logic                    dec_accept,
    input logic [8*ADDR_BYTES-1:0] dst,
    input logic [MODE_W-1:0]       mode,
    input logic [TBL_W-1:0]        hash_tbl
);

    localparam int SW = $clog2(ADDR_BYTES + 1) + 1;

    logic [SW-1:0] seen_q;
    logic          grp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              seen_q <= '0;
        else if (rx_valid && rx_first)           seen_q <= SW'(1);
        else if (seen_q == SW'(ADDR_BYTES))      seen_q <= '0;
        else if (rx_valid && seen_q != '0)       seen_q <= seen_q + SW'(1);
    end

    assign grp = dst[0] & ~(&dst);

    AST_VERDICT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid == (seen_q == SW'(ADDR_BYTES)));                         // R2
    AST_VERDICT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);                                         // R2
    AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);                                         // R3
    AST_BCAST_BIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (&dst)) |-> (dec_accept == mode[MODE_BCAST]));      // R9
    AST_PROMISC_UNICAST: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dst[0] && mode[MODE_PROMISC]) |-> dec_accept);     // R8
    AST_EMPTY_TABLE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && grp && hash_tbl == '0 && !mode[MODE_ALLMC]
         && !mode[MODE_PROMISC]) |-> !dec_accept);                         // R6
    AST_ALLMC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && grp && mode[MODE_ALLMC]) |-> dec_accept);           // R7

endmodule

bind eth_mcast_filter filt_hash_chk #(
    .ADDR_BYTES(ADDR_BYTES), .TBL_W(1 << HASH_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dst(dst_q),
    .mode(mode), .hash_tbl(hash_tbl)
);

// File: tb/tb_eth_mcast_filter.sv
module tb_eth_mcast_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic        rx_first = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        dec_valid;
    logic        dec_accept;
    logic [5:0]  dec_index;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [63:0] m_tbl   = '0;
    logic [2:0]  m_mode  = '0;
    logic [47:0] m_sta   = '0;

    always #5 clk = ~clk;

    eth_mcast_filter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_first(rx_first),
        .rx_byte(rx_byte), .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_index(dec_index)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 50000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // reference CRC index: init all ones, poly 04C11DB7, LSB of each byte first
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] b = a[47-8*k -: 8];
            for (int i = 0; i < 8; i++) begin
                logic fb = c[31] ^ b[i];
                c = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        c = ~c;
        return c[31:26];
    endfunction

    function automatic logic ref_accept(input logic [47:0] a);
        logic grp_all = (a == 48'hFFFF_FFFF_FFFF);
        logic force_all = m_mode[2] | m_mode[0];
        if (grp_all) return m_mode[1];
        if (a[40]) return (force_all | (|m_tbl)) & (force_all | m_tbl[ref_idx(a)]);
        return m_mode[0] | (a == m_sta);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 4'd0) m_tbl[31:0]  = d;
        if (a == 4'd1) m_tbl[63:32] = d;
        if (a == 4'd2) m_mode = d[2:0];
    endtask

    task automatic set_station(input logic [47:0] a);
        for (int k = 0; k < 6; k++) wr(4'(3 + k), {24'd0, a[47-8*k -: 8]});
        m_sta = a;
    endtask

    // drives the address, leaves the bench at the falling edge where the verdict is due
    task automatic send(input logic [47:0] a, input bit gaps);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k > 0) check("R2 no early verdict", 32'(dec_valid), 0);
            rx_valid = 1'b1; rx_first = (k == 0); rx_byte = a[47-8*k -: 8];
            if (gaps && k < 5) begin
                @(negedge clk);
                rx_valid = 1'b0; rx_first = 1'b0;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_first = 1'b0;
    endtask

    task automatic frame_check(input string tag, input logic [47:0] a, input bit gaps);
        send(a, gaps);
        check({tag, " R2 valid"}, 32'(dec_valid), 1);
        check({tag, " accept"}, 32'(dec_accept), 32'(ref_accept(a)));
        check({tag, " R4 index"}, 32'(dec_index), 32'(ref_idx(a)));
        @(negedge clk);
        check({tag, " R2 pulse ends"}, 32'(dec_valid), 0);
        check({tag, " R3 accept low"}, 32'(dec_accept), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 valid after reset", 32'(dec_valid), 0);
        check("R1 accept after reset", 32'(dec_accept), 0);
        // R1: station zero, so all-zero unicast matches with no writes
        frame_check("R1 zero station", 48'h0000_0000_0000, 1'b0);
    endtask

    task automatic t_unicast();
        set_station(48'h0211_2233_4455);
        frame_check("R8 match", 48'h0211_2233_4455, 1'b0);
        frame_check("R8 miss", 48'h0211_2233_4456, 1'b0);
        check("R8 miss rejected", 32'(ref_accept(48'h0211_2233_4456)), 0);
        wr(4'd2, 32'h1);
        frame_check("R8 promisc", 48'h00AA_BBCC_DDEE, 1'b0);
        wr(4'd2, 32'h0);
    endtask

    task automatic t_multicast();
        logic [47:0] g = 48'h0100_5E00_0001;
        logic [5:0]  ix = ref_idx(g);
        frame_check("R6 empty table", g, 1'b0);
        // R5: index below 32 lives in word 0, else word 1 at bit ix-32
        if (ix < 32) wr(4'd0, 32'(1) << ix);
        else         wr(4'd1, 32'(1) << (ix - 32));
        frame_check("R5 indexed bit", g, 1'b0);
        check("R5 model accepts", 32'(ref_accept(g)), 1);
        // R6: a different bit set only, still rejected
        wr(4'd0, '0); wr(4'd1, '0);
        if (ix < 32) wr(4'd1, 32'h1);
        else         wr(4'd0, 32'h1);
        frame_check("R6 other bit", g, 1'b0);
        check("R6 model rejects", 32'(ref_accept(g)), 0);
        wr(4'd0, '0); wr(4'd1, '0);
    endtask

    task automatic t_allmulti();
        wr(4'd2, 32'h4);
        frame_check("R7 allmulti", 48'h3333_0000_00FB, 1'b1);
        wr(4'd2, 32'h1);
        frame_check("R7 promisc group", 48'h0180_C200_000E, 1'b0);
        wr(4'd2, 32'h0);
    endtask

    task automatic t_broadcast();
        wr(4'd2, 32'h5);
        wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'hFFFF_FFFF);
        frame_check("R9 bcast off", 48'hFFFF_FFFF_FFFF, 1'b0);
        check("R9 bcast off model", 32'(ref_accept(48'hFFFF_FFFF_FFFF)), 0);
        wr(4'd2, 32'h2);
        wr(4'd0, '0); wr(4'd1, '0);
        frame_check("R9 bcast on", 48'hFFFF_FFFF_FFFF, 1'b1);
        wr(4'd2, 32'h0);
    endtask

    task automatic t_framing();
        // stray valid bytes with no first flag: no verdict
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_first = 1'b0; rx_byte = 8'(k);
            check("R2 stray ignored", 32'(dec_valid), 0);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        check("R2 stray ignored end", 32'(dec_valid), 0);
        @(negedge clk);
        check("R2 stray ignored late", 32'(dec_valid), 0);
        // partial frame then restart
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_first = (k == 0); rx_byte = 8'hA0 + 8'(k);
        end
        frame_check("R2 restart", 48'h0211_2233_4455, 1'b0);
        check("R2 restart model match", 32'(ref_accept(48'h0211_2233_4455)), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unicast();
        t_multicast();
        t_allmulti();
        t_broadcast();
        t_framing();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule